// File: doc/BRIEF.md
# Floating-Point NaN Screening Unit

This unit sits beside the arithmetic datapath of a floating-point pipeline and decides what an operation really writes back. For each operation it examines both source operands and the raw datapath result at the width chosen by a precision select, either 32-bit or 64-bit. When a source is a NaN, the unit writes that NaN in place of the datapath result. A signalling NaN is first turned into the default quiet NaN of the operand width, and a quiet NaN is passed on bit for bit. When neither source is a NaN but the datapath still produced one, the unit writes the default quiet NaN and records an invalid-operation event in its status word.

The status word is 32 bits wide. Every operation clears the per-operation cause field in bits 17:12 and keeps all other bits. An invalid event sets cause bit 16 and the sticky flag bit 6. Only the status write port can clear the sticky flag. Every output is registered and changes one cycle after the operation strobe.

Top module: `fp_nan_screen`

## Requirements
- R1: `resWrEn` is 1 in the cycle after a cycle with `opValid` high and 0 after any cycle with `opValid` low. `resData` changes only one cycle after an operation.
- R2: `isDouble`=1 selects 64-bit operands. `isDouble`=0 selects 32-bit operands in bits 31:0, and in that mode bits 63:32 of every input are ignored and `resData[63:32]` is written as 0. A value is a NaN when its exponent field (bits 62:52 or 30:23) is all ones and its fraction field (bits 51:0 or 22:0) is nonzero.
- R3: A NaN source whose fraction MSB (bit 51 or bit 22) is 1 is signalling. It produces the default quiet NaN 0x7FF7FFFFFFFFFFFF (64-bit) or 0x7FBFFFFF (32-bit).
- R4: A NaN source whose fraction MSB is 0 is quiet and is written unchanged.
- R5: When both sources are NaN, source A decides the written value.
- R6: When no source is a NaN and `rawResult` is a NaN, the default quiet NaN of the width is written, and status bits 16 (cause) and 6 (sticky flag) are set.
- R7: When no source and no result is a NaN, `rawResult` is written (zero-extended in 32-bit mode).
- R8: Each operation clears status bits 17:12 and keeps bits 31:18 and 11:0, except for the invalid bits set by R6.
- R9: Bit 6 stays set through later operations. A `statusWrEn` write replaces the whole status word in the next cycle. When a write and an operation fall in the same cycle, the operation's update is applied on top of the written value.
- R10: A NaN source suppresses `rawResult`, even when it is a NaN, and raises no invalid bits.
- R11: After reset, `resWrEn`, `resData` and `statusOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation strobe |
| isDouble | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand |
| rawResult | input | 64 | Unscreened datapath result |
| statusWrEn | input | 1 | Status word write strobe |
| statusWrData | input | 32 | Status word write value |
| resWrEn | output | 1 | Result write enable |
| resData | output | 64 | Screened result |
| statusOut | output | 32 | Current status word |

## Verification
Every result comes out of a single register stage. The write enable, the result value and the status word for an operation sampled at one clock edge are all due at the following edge. A status write on its own shows up after the same one-cycle delay. The bench drives inputs on the falling edge and compares all three outputs on the next falling edge, which falls halfway through the cycle after the sampling edge. Idle gaps after each operation confirm that the write enable drops and that the result and status hold their values.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;
  localparam int DATA_W = 64;
  localparam int STAT_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] DFLT_QNAN_D = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam logic [HALF_W-1:0] DFLT_QNAN_S = 32'h7FBF_FFFF;
  localparam int CAUSE_LO = 12;
  localparam int CAUSE_HI = 17;
  localparam int CAUSE_INV = 16;
  localparam int FLAG_INV = 6;

  typedef struct packed {
    logic load;
    logic takeA;
    logic takeB;
    logic dfltNan;
    logic raiseInv;
  } scrStrobe_t;

  function automatic logic isNanVal(input logic [DATA_W-1:0] v, input logic dbl);
    if (dbl) return (&v[62:52]) && (|v[51:0]);
    return (&v[30:23]) && (|v[22:0]);
  endfunction

  function automatic logic isSigVal(input logic [DATA_W-1:0] v, input logic dbl);
    return isNanVal(v, dbl) && (dbl ? v[51] : v[22]);
  endfunction
endpackage

// File: rtl/fp_nan_ctrl.sv
module fp_nan_ctrl
  import fp_nan_pkg::*;
(
  input  logic              opValid,
  input  logic              isDouble,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] rawResult,
  output scrStrobe_t        strobe
);
  localparam int NSRC = 2;
  logic [DATA_W-1:0] srcVec [NSRC];
  logic [NSRC-1:0] srcNan;
  logic [NSRC-1:0] srcSig;
  logic resNan;

  assign srcVec[0] = srcA;
  assign srcVec[1] = srcB;

  for (genvar i = 0; i < NSRC; i++) begin : g_cls
    assign srcNan[i] = isNanVal(srcVec[i], isDouble);
    assign srcSig[i] = isSigVal(srcVec[i], isDouble);
  end

  assign resNan = isNanVal(rawResult, isDouble);

  always_comb begin
    strobe = '0;
    strobe.load = opValid;
    if (srcNan[0]) begin
      strobe.takeA   = !srcSig[0];
      strobe.dfltNan = srcSig[0];
    end else if (srcNan[1]) begin
      strobe.takeB   = !srcSig[1];
      strobe.dfltNan = srcSig[1];
    end else if (resNan) begin
      strobe.dfltNan  = 1'b1;
      strobe.raiseInv = opValid;
    end
  end
endmodule

// File: rtl/fp_nan_dp.sv
module fp_nan_dp
  import fp_nan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  scrStrobe_t        strobe,
  input  logic              isDouble,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] rawResult,
  input  logic              statusWrEn,
  input  logic [STAT_W-1:0] statusWrData,
  output logic              resWrEn,
  output logic [DATA_W-1:0] resData,
  output logic [STAT_W-1:0] statusOut
);
  logic [DATA_W-1:0] pick;
  logic [DATA_W-1:0] pickMasked;
  logic [STAT_W-1:0] statusNext;

  always_comb begin
    if (strobe.takeA)        pick = srcA;
    else if (strobe.takeB)   pick = srcB;
    else if (strobe.dfltNan) pick = isDouble ? DFLT_QNAN_D : {{HALF_W{1'b0}}, DFLT_QNAN_S};
    else                     pick = rawResult;
    pickMasked = isDouble ? pick : {{HALF_W{1'b0}}, pick[HALF_W-1:0]};
  end

  always_comb begin
    statusNext = statusWrEn ? statusWrData : statusOut;
    if (strobe.load) begin
      statusNext[CAUSE_HI:CAUSE_LO] = '0;
      if (strobe.raiseInv) begin
        statusNext[CAUSE_INV] = 1'b1;
        statusNext[FLAG_INV]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resWrEn   <= 1'b0;
      resData   <= '0;
      statusOut <= '0;
    end else begin
      resWrEn   <= strobe.load;
      statusOut <= statusNext;
      if (strobe.load) resData <= pickMasked;
    end
  end
endmodule

// File: rtl/fp_nan_screen.sv
module fp_nan_screen
  import fp_nan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              isDouble,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] rawResult,
  input  logic              statusWrEn,
  input  logic [STAT_W-1:0] statusWrData,
  output logic              resWrEn,
  output logic [DATA_W-1:0] resData,
  output logic [STAT_W-1:0] statusOut
);
  scrStrobe_t strobe;

  fp_nan_ctrl u_ctrl (
    .opValid(opValid), .isDouble(isDouble), .srcA(srcA), .srcB(srcB),
    .rawResult(rawResult), .strobe(strobe)
  );

  fp_nan_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isDouble(isDouble),
    .srcA(srcA), .srcB(srcB), .rawResult(rawResult),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .resWrEn(resWrEn), .resData(resData), .statusOut(statusOut)
  );
endmodule

// File: rtl/fp_nan_screen_chk.sv
module fp_nan_screen_chk
  import fp_nan_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              isDouble,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [DATA_W-1:0] rawResult,
  input logic              statusWrEn,
  input logic [STAT_W-1:0] statusWrData,
  input logic              resWrEn,
  input logic [DATA_W-1:0] resData,
  input logic [STAT_W-1:0] statusOut
);
  p_wren_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resWrEn);
  p_wren_clr_r1: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resWrEn && $stable(resData)));
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isDouble) |=> (resData[63:32] == '0));
  p_quiet_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isDouble && isNanVal(srcA, 1'b1) && !srcA[51]) |=> (resData == $past(srcA)));
  p_cause_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !statusWrEn) |=>
      (statusOut[17] == 1'b0 && statusOut[15:12] == '0 &&
       statusOut[31:18] == $past(statusOut[31:18]) &&
       statusOut[11:7] == $past(statusOut[11:7]) &&
       statusOut[5:0] == $past(statusOut[5:0])));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[6] && !statusWrEn) |=> statusOut[6]);
  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !statusWrEn) |=> $stable(statusOut));
  p_no_inv_on_nan_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !statusWrEn && isNanVal(srcA, isDouble)) |=> !statusOut[16]);
endmodule

bind fp_nan_screen fp_nan_screen_chk u_chk (.*);

// File: tb/fp_nan_screen_bench.sv
`timescale 1ns/1ps
module fp_nan_screen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic isDouble = 1'b0;
  logic [63:0] srcA = '0, srcB = '0, rawResult = '0;
  logic statusWrEn = 1'b0;
  logic [31:0] statusWrData = '0;
  logic resWrEn;
  logic [63:0] resData;
  logic [31:0] statusOut;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] modelStatus = '0;
  logic [63:0] modelRes = '0;

  always #2 clk = ~clk;

  fp_nan_screen u_fp_nan_screen (
    .clk(clk), .rstN(rstN), .opValid(opValid), .isDouble(isDouble),
    .srcA(srcA), .srcB(srcB), .rawResult(rawResult),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .resWrEn(resWrEn), .resData(resData), .statusOut(statusOut)
  );

  function automatic bit bNan(input logic [63:0] v, input bit d);
    if (d) return v[62:52] == 11'h7FF && v[51:0] != 0;
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction

  function automatic bit bSig(input logic [63:0] v, input bit d);
    return bNan(v, d) && (d ? v[51] : v[22]);
  endfunction

  function automatic logic [63:0] dflt(input bit d);
    return d ? 64'h7FF7FFFFFFFFFFFF : 64'h000000007FBFFFFF;
  endfunction

  // kind: 0 ordinary, 1 quiet NaN, 2 signalling NaN, 3 infinity, 4 zero
  function automatic logic [63:0] mkVal(input int kind, input bit d);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (d) begin
      case (kind)
        1: begin v[62:52] = '1; v[51] = 1'b0; v[0] = 1'b1; end
        2: begin v[62:52] = '1; v[51] = 1'b1; end
        3: begin v[62:52] = '1; v[51:0] = '0; end
        4: v[62:0] = '0;
        default: if (v[62:52] == 11'h7FF) v[62] = 1'b0;
      endcase
    end else begin
      case (kind)
        1: begin v[30:23] = '1; v[22] = 1'b0; v[1] = 1'b1; end
        2: begin v[30:23] = '1; v[22] = 1'b1; end
        3: begin v[30:23] = '1; v[22:0] = '0; end
        4: v[30:0] = '0;
        default: if (v[30:23] == 8'hFF) v[30] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic fail(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nFails++;
    $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) fail(tag, act, exp);
  endtask

  // applies one operation, optionally with a same-cycle status write (R9)
  task automatic doOp(input bit d, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] r, input bit wr, input logic [31:0] wdat);
    string tag;
    bit inv;
    logic [63:0] exp;
    inv = 0;
    if (bNan(a, d)) begin
      exp = bSig(a, d) ? dflt(d) : a;
      tag = bSig(a, d) ? "R3/R5" : "R4/R5";
      if (bNan(b, d) || bNan(r, d)) tag = {tag, "/R10"};
    end else if (bNan(b, d)) begin
      exp = bSig(b, d) ? dflt(d) : b;
      tag = bSig(b, d) ? "R3" : "R4";
      if (bNan(r, d)) tag = {tag, "/R10"};
    end else if (bNan(r, d)) begin
      exp = dflt(d); inv = 1; tag = "R6";
    end else begin
      exp = r; tag = "R7";
    end
    if (!d) exp[63:32] = '0;
    if (wr) modelStatus = wdat;
    modelStatus[17:12] = '0;
    if (inv) begin modelStatus[16] = 1'b1; modelStatus[6] = 1'b1; end
    modelRes = exp;
    @(negedge clk);
    isDouble = d; srcA = a; srcB = b; rawResult = r; opValid = 1'b1;
    statusWrEn = wr; statusWrData = wdat;
    @(negedge clk);
    opValid = 1'b0; statusWrEn = 1'b0;
    chk("R1 wrEn after strobe", {63'b0, resWrEn}, 64'd1);
    chk({tag, d ? " R2 dbl" : " R2 sgl"}, resData, exp);
    chk({"R8/R9 status ", tag}, {32'b0, statusOut}, {32'b0, modelStatus});
    @(negedge clk);
    chk("R1 idle wrEn low", {63'b0, resWrEn}, 64'd0);
    chk("R1 idle data held", resData, modelRes);
  endtask

  task automatic swWrite(input logic [31:0] w);
    @(negedge clk);
    statusWrEn = 1'b1; statusWrData = w;
    @(negedge clk);
    statusWrEn = 1'b0;
    modelStatus = w;
    chk("R9 status write", {32'b0, statusOut}, {32'b0, w});
  endtask

  initial begin
    #(4 * 150000);
    fail("watchdog", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset wrEn", {63'b0, resWrEn}, 64'd0);
    chk("R11 reset data", resData, 64'd0);
    chk("R11 reset status", {32'b0, statusOut}, 64'd0);

    // directed corners
    swWrite(32'hFFFF_F0BF);                                          // R9 flag bit 6 initially clear
    doOp(1, 64'h7FF8_0000_0000_0001, 64'h3FF0_0000_0000_0000, 64'h0, 0, 0);   // R3 64-bit signalling
    doOp(0, 64'hDEAD_BEEF_7FC0_0001, 64'h0, 64'h1234_5678_3F80_0000, 0, 0);  // R3 32-bit
    doOp(1, 64'hFFF0_0000_0000_0005, 64'h0, 64'h0, 0, 0);             // R4 quiet negative
    doOp(0, 64'hFFFF_FFFF_7F80_0010, 64'h0, 64'h0, 0, 0);             // R4 32-bit quiet
    doOp(1, 64'h7FF0_0000_0000_0003, 64'h7FF8_0000_0000_0001, 64'h0, 0, 0); // R5 A wins
    doOp(1, 64'h7FF0_0000_0000_0000, 64'h1, 64'h7FF8_0000_0000_0009, 0, 0); // R6 inf in, NaN out
    doOp(1, 64'h1, 64'h2, 64'h4000_0000_0000_0000, 0, 0);            // R9 flag sticks
    chk("R9 flag sticky", {63'b0, statusOut[6]}, 64'd1);
    doOp(0, 64'h0, 64'h7F80_0001, 64'h7FC0_0000, 0, 0);              // R10 src NaN beats result NaN
    doOp(0, 64'hFFFF_FFFF_0000_0000, 64'h1, 64'hFFFF_FFFF_7F80_0000, 0, 0); // R7 inf result, upper garbage
    swWrite(32'h0000_0000);                                           // R9 clear flag
    doOp(0, 64'h0, 64'h0, 64'h7F80_0001, 1, 32'h0003_F000);          // R9 write with op
    doOp(1, 64'h1, 64'h1, 64'h2, 1, 32'hA5A5_A5A5);                  // R8 cause cleared over write

    // constrained random
    for (int i = 0; i < 400; i++) begin
      bit d;
      int ka, kb, kr;
      d  = $urandom_range(0, 1);
      ka = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 0;
      kb = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 0;
      kr = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 4) : 0;
      if ($urandom_range(0, 15) == 0) swWrite($urandom);
      doOp(d, mkVal(ka, d), mkVal(kb, d), mkVal(kr, d),
           $urandom_range(0, 9) == 0, $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule